// File: doc/BRIEF.md
# EDO DRAM Page-Mode Controller

This block sits between a simple request/response host port and one 1M x 4 extended-data-out DRAM. The host offers a 20-bit word address with a read or write flag and 4 bits of write data. The controller splits the address into a row half and a column half. It presents both halves on one shared 10-bit pin bus and drives the active-low row strobe, column strobe, write enable and output enable. The data pins are split into a drive value, a drive enable and a sampled input, so that a pad ring can build the tri-state buffer.

Once a row is opened it stays open, and further requests to the same row are served as back-to-back column accesses without another row activation. A request to a different row closes the row, waits out the precharge time and opens the new row. A cycle counter caps how long the row strobe may stay low. When the cap is near, the controller closes the row even if hitting requests are waiting. Writes are always early writes. Reads sample the data bus on the clock edge that raises the column strobe, which works because the memory keeps its output driven after that strobe rises. Refresh is left to an outside engine. It asks through `ref_req`, and the controller closes the row, precharges and answers with `ref_gnt` while both strobes stay high.

All analogue timings are passed in as clock-cycle counts (nanosecond minimum divided by the clock period, rounded up).

Top module: `edo_page_ctrl`

## Requirements
- R1: A request address splits as row = `req_addr[19:10]` and column = `req_addr[9:0]`. The row is on `dram_a` from at least one cycle before the row strobe falls, and the column is on `dram_a` from at least one cycle before the column strobe falls and stays unchanged while it is low.
- R2: A write (`req_write`=1) is an early write. `dram_we_n` is low from at least one cycle before the column strobe falls until it rises. `dram_dq_oe`=1 with the write data on `dram_dq_out` for the same span, and `dram_oe_n` is high.
- R3: A read keeps `dram_we_n` high and `dram_oe_n` low while the column strobe is low. `rsp_valid` pulses for one cycle, in the cycle the column strobe goes high, with `rsp_rdata` holding `dram_dq_in` as sampled at that clock edge. Responses come in request order.
- R4: Requests to the row already open are served with no further falling edge of the row strobe.
- R5: A request to another row raises the row strobe. The row strobe then stays high for at least `T_RP` cycles before it falls again.
- R6: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles. The row is closed at that limit even while same-row requests keep arriving.
- R7: The column strobe stays low for at least `T_CAS` cycles. Within one open row it stays high for at least `T_CP` cycles between accesses.
- R8: The column strobe falls no sooner than `T_RCD` cycles after the row strobe falls.
- R9: While `ref_req`=1 no request is accepted, any open row is closed, and `ref_gnt` rises only with both strobes high. After `ref_req` falls, `ref_gnt` drops and the row strobe stays high for at least `T_RP` more cycles.
- R10: After reset, all four strobes are high, `dram_dq_oe`=0, `rsp_valid`=0, `ref_gnt`=0 and `req_ready`=1.
- R11: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Host request taken this cycle when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in upper half, column in lower half |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 4 | Read data |
| ref_req | input | 1 | Outside refresh engine asks for the memory |
| ref_gnt | output | 1 | Memory handed over, both strobes high |
| dram_a | output | 10 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 4 | Data to drive onto the pins |
| dram_dq_oe | output | 1 | Drive enable for the data pins |
| dram_dq_in | input | 4 | Data sampled from the pins |

## Verification
The checker watches the pin-level timing on every cycle. It checks the row-low cap, the precharge gap, the column-strobe width, the row-to-column delay, the column strobe staying inside a low row strobe, the stability of write enable and column address while the column strobe is low, the pairing of data drive with write enable, and the idle pins under a refresh grant. Only the bench scenarios can show that data lands at the right row and column and reads back intact. They also show that a same-row burst costs exactly one row activation, that misses each cost one, and that a long stream of hits is cut by the row-low cap.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_RCD,
    S_COL,
    S_CASLO,
    S_PAGE,
    S_PRE,
    S_GNT
  } seq_state_e;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned cnt_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             done
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nx;
  logic             cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_nx = cnt_q;
    if (load) begin
      cnt_nx = load_val;
    end else if (cnt_q != '0) begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nx;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
  parameter int unsigned LIMIT = 25000,
  parameter int unsigned GUARD = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic near_limit
);

  localparam int unsigned CW = edo_pkg::cnt_bits(LIMIT);
  localparam logic [CW-1:0] THRESH = CW'(LIMIT - GUARD);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] low_q;
  logic [CW-1:0] low_nx;
  logic          low_en;

  always_comb begin
    low_nx = '0;
    if (ras_low) begin
      low_nx = (low_q == CMAX) ? low_q : low_q + 1'b1;
    end
  end

  assign low_en = ras_low || (low_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (low_en) begin
      low_q <= low_nx;
    end
  end

  // Completed low cycles beyond the threshold leave no room for one more access.
  assign near_limit = ras_low && (low_q > THRESH);

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W = 10,
  parameter int unsigned COL_W = 10,
  parameter int unsigned DQ_W  = 4,
  parameter int unsigned PIN_W = 10,
  parameter int unsigned TW    = 4,
  parameter int unsigned T_RP  = 10,
  parameter int unsigned T_RCD = 5,
  parameter int unsigned T_CAS = 4,
  parameter int unsigned T_CP  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  input  logic                   ref_req,
  output logic                   ref_gnt,
  output logic [PIN_W-1:0]       dram_a,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DQ_W-1:0]        dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DQ_W-1:0]        dram_dq_in,
  input  logic                   t_done,
  output logic                   t_load,
  output logic [TW-1:0]          t_val,
  input  logic                   near_limit
);

  localparam logic [TW-1:0] LD_RP  = TW'(T_RP - 1);
  localparam logic [TW-1:0] LD_RCD = TW'(T_RCD - 1);
  localparam logic [TW-1:0] LD_CAS = TW'(T_CAS - 1);
  localparam logic [TW-1:0] LD_CP  = TW'(T_CP - 1);

  seq_state_e st_q, st_nx;
  logic ras_q, ras_nx, cas_q, cas_nx, we_q, we_nx, oe_q, oe_nx;
  logic [PIN_W-1:0] a_q, a_nx;
  logic [DQ_W-1:0]  dqo_q, dqo_nx, rd_q, rd_nx, wd_q, wd_nx;
  logic dqe_q, dqe_nx, rv_q, rv_nx, gnt_q, gnt_nx, wr_q, wr_nx;
  logic [ROW_W-1:0] row_q, row_nx;
  logic [COL_W-1:0] col_q, col_nx;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             row_hit;
  logic             must_close;

  assign req_row    = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col    = req_addr[COL_W-1:0];
  assign row_hit    = (req_row == row_q);
  assign must_close = ref_req || near_limit || (req_valid && !row_hit);

  always_comb begin
    st_nx     = st_q;
    ras_nx    = ras_q;
    cas_nx    = cas_q;
    we_nx     = we_q;
    oe_nx     = oe_q;
    a_nx      = a_q;
    dqo_nx    = dqo_q;
    dqe_nx    = dqe_q;
    rv_nx     = 1'b0;
    rd_nx     = rd_q;
    gnt_nx    = gnt_q;
    row_nx    = row_q;
    col_nx    = col_q;
    wr_nx     = wr_q;
    wd_nx     = wd_q;
    t_load    = 1'b0;
    t_val     = '0;
    req_ready = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (ref_req) begin
          gnt_nx = 1'b1;
          st_nx  = S_GNT;
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            row_nx = req_row;
            col_nx = req_col;
            wr_nx  = req_write;
            wd_nx  = req_wdata;
            a_nx   = PIN_W'(req_row);
            st_nx  = S_ACT;
          end
        end
      end
      S_ACT: begin
        ras_nx = 1'b0;
        t_load = 1'b1;
        t_val  = LD_RCD;
        st_nx  = S_RCD;
      end
      S_RCD: begin
        if (t_done) begin
          a_nx   = PIN_W'(col_q);
          we_nx  = ~wr_q;
          oe_nx  = wr_q;
          dqe_nx = wr_q;
          dqo_nx = wd_q;
          st_nx  = S_COL;
        end
      end
      S_COL: begin
        cas_nx = 1'b0;
        t_load = 1'b1;
        t_val  = LD_CAS;
        st_nx  = S_CASLO;
      end
      S_CASLO: begin
        if (t_done) begin
          cas_nx = 1'b1;
          we_nx  = 1'b1;
          dqe_nx = 1'b0;
          if (!wr_q) begin
            rv_nx = 1'b1;
            rd_nx = dram_dq_in;
          end
          t_load = 1'b1;
          t_val  = LD_CP;
          st_nx  = S_PAGE;
        end
      end
      S_PAGE: begin
        if (must_close) begin
          ras_nx = 1'b1;
          oe_nx  = 1'b1;
          t_load = 1'b1;
          t_val  = LD_RP;
          st_nx  = S_PRE;
        end else if (t_done) begin
          req_ready = 1'b1;
          if (req_valid) begin
            wr_nx  = req_write;
            a_nx   = PIN_W'(req_col);
            we_nx  = ~req_write;
            oe_nx  = req_write;
            dqe_nx = req_write;
            dqo_nx = req_wdata;
            st_nx  = S_COL;
          end
        end
      end
      S_PRE: begin
        if (t_done) st_nx = S_IDLE;
      end
      S_GNT: begin
        if (!ref_req) begin
          gnt_nx = 1'b0;
          t_load = 1'b1;
          t_val  = LD_RP;
          st_nx  = S_PRE;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
      oe_q  <= 1'b1;
      a_q   <= '0;
      dqo_q <= '0;
      dqe_q <= 1'b0;
      rv_q  <= 1'b0;
      rd_q  <= '0;
      gnt_q <= 1'b0;
      row_q <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
    end else begin
      st_q  <= st_nx;
      ras_q <= ras_nx;
      cas_q <= cas_nx;
      we_q  <= we_nx;
      oe_q  <= oe_nx;
      a_q   <= a_nx;
      dqo_q <= dqo_nx;
      dqe_q <= dqe_nx;
      rv_q  <= rv_nx;
      rd_q  <= rd_nx;
      gnt_q <= gnt_nx;
      row_q <= row_nx;
      col_q <= col_nx;
      wr_q  <= wr_nx;
      wd_q  <= wd_nx;
    end
  end

  assign rsp_valid   = rv_q;
  assign rsp_rdata   = rd_q;
  assign ref_gnt     = gnt_q;
  assign dram_a      = a_q;
  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_we_n   = we_q;
  assign dram_oe_n   = oe_q;
  assign dram_dq_out = dqo_q;
  assign dram_dq_oe  = dqe_q;

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DQ_W      = 4,
  parameter int unsigned T_RP      = 10,
  parameter int unsigned T_RCD     = 5,
  parameter int unsigned T_CAS     = 4,
  parameter int unsigned T_CP      = 3,
  parameter int unsigned T_RAS_MAX = 25000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ROW_W+COL_W-1:0]      req_addr,
  input  logic [DQ_W-1:0]             req_wdata,
  output logic                        rsp_valid,
  output logic [DQ_W-1:0]             rsp_rdata,
  input  logic                        ref_req,
  output logic                        ref_gnt,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a,
  output logic                        dram_ras_n,
  output logic                        dram_cas_n,
  output logic                        dram_we_n,
  output logic                        dram_oe_n,
  output logic [DQ_W-1:0]             dram_dq_out,
  output logic                        dram_dq_oe,
  input  logic [DQ_W-1:0]             dram_dq_in
);

  localparam int unsigned PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned TMAX  = edo_pkg::max_of4(T_RP, T_RCD, T_CAS, T_CP);
  localparam int unsigned TW    = edo_pkg::cnt_bits(TMAX);
  // One accepted access keeps the row low for setup, strobe and one decision cycle.
  localparam int unsigned GUARD = T_CAS + 3;

  logic          t_done;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          near_limit;

  edo_cycle_timer #(.WIDTH(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  edo_ras_window #(.LIMIT(T_RAS_MAX), .GUARD(GUARD)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_low    (~dram_ras_n),
    .near_limit (near_limit)
  );

  edo_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .DQ_W (DQ_W), .PIN_W (PIN_W), .TW (TW),
    .T_RP  (T_RP),  .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CP (T_CP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .ref_req     (ref_req),
    .ref_gnt     (ref_gnt),
    .dram_a      (dram_a),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_oe_n   (dram_oe_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_oe  (dram_dq_oe),
    .dram_dq_in  (dram_dq_in),
    .t_done      (t_done),
    .t_load      (t_load),
    .t_val       (t_val),
    .near_limit  (near_limit)
  );

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int unsigned PIN_W     = 10,
  parameter int unsigned T_RP      = 10,
  parameter int unsigned T_RCD     = 5,
  parameter int unsigned T_CAS     = 4,
  parameter int unsigned T_RAS_MAX = 25000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             ref_gnt,
  input logic [PIN_W-1:0] dram_a,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_oe_n,
  input logic             dram_dq_oe
);

  int unsigned ras_lo_q;
  int unsigned ras_hi_q;
  int unsigned cas_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_q <= 0;
      ras_hi_q <= T_RP;
      cas_lo_q <= 0;
    end else begin
      ras_lo_q <= dram_ras_n ? 0 : ((ras_lo_q > T_RAS_MAX) ? ras_lo_q : ras_lo_q + 1);
      ras_hi_q <= !dram_ras_n ? 0 : ((ras_hi_q >= T_RP) ? ras_hi_q : ras_hi_q + 1);
      cas_lo_q <= dram_cas_n ? 0 : ((cas_lo_q >= T_CAS) ? cas_lo_q : cas_lo_q + 1);
    end
  end

  p_ras_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_lo_q < T_RAS_MAX));

  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi_q >= T_RP));

  p_cas_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> (cas_lo_q >= T_CAS));

  p_rcd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_lo_q >= T_RCD));

  p_cas_in_row_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  p_we_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_we_n));

  p_col_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_a));

  p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n));

  p_rsp_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($rose(dram_cas_n) && dram_we_n));

  p_grant_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .PIN_W     ((ROW_W > COL_W) ? ROW_W : COL_W),
  .T_RP      (T_RP),
  .T_RCD     (T_RCD),
  .T_CAS     (T_CAS),
  .T_RAS_MAX (T_RAS_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ref_gnt    (ref_gnt),
  .dram_a     (dram_a),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/edo_page_ctrl_bench.sv
`timescale 1ns/1ps
module edo_page_ctrl_bench;

  localparam int unsigned B_RP   = 3;
  localparam int unsigned B_RCD  = 2;
  localparam int unsigned B_CAS  = 3;
  localparam int unsigned B_CP   = 2;
  localparam int unsigned B_RMAX = 120;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [19:0] req_addr;
  logic [3:0]  req_wdata;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic        ref_req;
  logic        ref_gnt;
  logic [9:0]  dram_a;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [3:0]  dram_dq_out;
  logic        dram_dq_oe;
  logic [3:0]  dram_dq_in;

  edo_page_ctrl #(
    .T_RP (B_RP), .T_RCD (B_RCD), .T_CAS (B_CAS), .T_CP (B_CP), .T_RAS_MAX (B_RMAX)
  ) u_edo_page_ctrl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .ref_req (ref_req), .ref_gnt (ref_gnt),
    .dram_a (dram_a), .dram_ras_n (dram_ras_n), .dram_cas_n (dram_cas_n),
    .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
    .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct packed { logic wr; logic [19:0] addr; logic [3:0] d; } acc_t;
  acc_t        accq[$];
  logic [3:0]  readq[$];
  logic [3:0]  refmem[int];
  logic [3:0]  dmem[int];

  function automatic logic [19:0] mk(input int r, input int c);
    return {10'(r), 10'(c)};
  endfunction

  function automatic logic [3:0] ref_read(input logic [19:0] a);
    return refmem.exists(int'(a)) ? refmem[int'(a)] : 4'h0;
  endfunction

  // Memory model and pin-timing monitor, sampled away from the active edge.
  logic p_ras, p_cas, p_we, p_dqe;
  logic [9:0] p_a, cur_row;
  int lo_len, hi_len, cas_lo, cas_hi, since_ras, ras_falls;
  bit cas_hi_ok;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; p_dqe = 0; p_a = '0; cur_row = '0;
      lo_len = 0; hi_len = 1000; cas_lo = 0; cas_hi = 0; since_ras = 0;
      ras_falls = 0; cas_hi_ok = 0; dram_dq_in = 4'h0;
    end else begin
      if (p_ras && !dram_ras_n) begin
        chk(dram_a == p_a, "R1 row address set up before row strobe", dram_a, p_a);
        chk(hi_len >= B_RP, "R5 precharge gap", hi_len, B_RP);
        cur_row = dram_a; ras_falls++; lo_len = 0; since_ras = 0; cas_hi_ok = 0;
      end
      if (!p_ras && dram_ras_n) begin
        chk(lo_len <= B_RMAX, "R6 row strobe low length", lo_len, B_RMAX);
        hi_len = 0;
      end
      if (!dram_cas_n && dram_ras_n)
        chk(0, "R11 column strobe low with row strobe high", 1, 0);
      if (p_cas && !dram_cas_n) begin
        chk(since_ras >= B_RCD, "R8 row to column delay", since_ras, B_RCD);
        chk(dram_a == p_a, "R1 column address set up", dram_a, p_a);
        if (cas_hi_ok) chk(cas_hi >= B_CP, "R7 column strobe high width", cas_hi, B_CP);
        if (accq.size() == 0) begin
          chk(0, "R1 unexpected column access", 1, 0);
        end else begin
          acc_t e;
          e = accq.pop_front();
          chk({cur_row, dram_a} == e.addr, "R1 row and column on pins", {cur_row, dram_a}, e.addr);
          if (e.wr) begin
            chk(!dram_we_n && !p_we, "R2 early write enable", {p_we, dram_we_n}, 0);
            chk(dram_dq_oe && p_dqe, "R2 data drive enable", {p_dqe, dram_dq_oe}, 3);
            chk(dram_oe_n, "R2 output enable off on write", dram_oe_n, 1);
            chk(dram_dq_out == e.d, "R2 write data", dram_dq_out, e.d);
            dmem[int'({cur_row, dram_a})] = dram_dq_out;
          end else begin
            chk(dram_we_n && p_we, "R3 write enable high on read", {p_we, dram_we_n}, 3);
            chk(!dram_oe_n, "R3 output enable on read", dram_oe_n, 0);
            dram_dq_in = dmem.exists(int'({cur_row, dram_a})) ? dmem[int'({cur_row, dram_a})] : 4'h0;
          end
        end
        cas_lo = 0;
      end
      if (!p_cas && dram_cas_n) begin
        chk(cas_lo >= B_CAS, "R7 column strobe low width", cas_lo, B_CAS);
        cas_hi = 0; cas_hi_ok = 1;
      end
      if (dram_ras_n && dram_cas_n) dram_dq_in = 4'h0;
      if (dram_ras_n) hi_len++; else begin lo_len++; since_ras++; end
      if (dram_cas_n) cas_hi++; else cas_lo++;
      if (rsp_valid) begin
        if (readq.size() == 0) chk(0, "R3 unexpected response", 1, 0);
        else begin
          logic [3:0] ex;
          ex = readq.pop_front();
          chk(rsp_rdata == ex, "R3 read data", rsp_rdata, ex);
        end
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_dqe = dram_dq_oe; p_a = dram_a;
    end
  end

  task automatic issue(input logic wr, input logic [19:0] addr, input logic [3:0] d);
    acc_t e;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    e.wr = wr; e.addr = addr; e.d = d;
    accq.push_back(e);
    if (wr) refmem[int'(addr)] = d;
    else readq.push_back(ref_read(addr));
    #1;
    req_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((readq.size() != 0 || accq.size() != 0) && n < 5000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic do_refresh();
    int n = 0;
    @(negedge clk);
    ref_req = 1;
    while (!ref_gnt && n < 1000) begin @(negedge clk); n++; end
    chk(ref_gnt, "R9 grant given", ref_gnt, 1);
    chk(dram_ras_n && dram_cas_n, "R9 strobes high under grant", {dram_ras_n, dram_cas_n}, 3);
    req_valid = 1; req_write = 0; req_addr = mk(2, 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!req_ready, "R9 no request taken during grant", req_ready, 0);
    end
    chk(dram_ras_n, "R9 row stays closed during grant", dram_ras_n, 1);
    req_valid = 0;
    ref_req = 0;
    @(negedge clk);
    chk(!ref_gnt, "R9 grant dropped after release", ref_gnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    void'($urandom(32'd1234567));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; ref_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n} == 4'hf, "R10 strobes high after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hf);
    chk(!dram_dq_oe && !rsp_valid && !ref_gnt, "R10 drive, response, grant low after reset",
        {dram_dq_oe, rsp_valid, ref_gnt}, 0);
    chk(req_ready, "R10 ready after reset", req_ready, 1);

    // Corner addresses: write then read back.
    issue(1, mk(1023, 1023), 4'ha);
    issue(1, mk(0, 0), 4'h5);
    issue(0, mk(1023, 1023), 4'h0);
    issue(0, mk(0, 0), 4'h0);
    drain();

    // R4: a same-row burst opens the row once.
    issue(1, mk(7, 5), 4'h3);
    drain();
    f0 = ras_falls;
    for (int c = 0; c < 4; c++) issue(0, mk(9, c), 4'h0);
    drain();
    chk(ras_falls - f0 == 1, "R4 one activation for a same-row burst", ras_falls - f0, 1);

    // R5: each row change costs an activation.
    f0 = ras_falls;
    issue(1, mk(3, 1), 4'h9);
    issue(1, mk(4, 2), 4'h6);
    issue(0, mk(3, 1), 4'h0);
    drain();
    chk(ras_falls - f0 == 3, "R5 activation on every row change", ras_falls - f0, 3);

    // R9: refresh grant with a row open.
    issue(0, mk(4, 2), 4'h0);
    do_refresh();
    drain();

    // R6: a long stream of hits is cut by the row-low cap.
    f0 = ras_falls;
    for (int c = 0; c < 40; c++) issue(0, mk(11, c), 4'h0);
    drain();
    chk(ras_falls - f0 >= 2, "R6 row closed at cap despite hits", ras_falls - f0, 2);

    // Random mix over a few rows.
    for (int i = 0; i < 400; i++) begin
      int r;
      int pick;
      pick = $urandom % 5;
      r = (pick == 4) ? 1023 : pick;
      if ($urandom % 4 == 0) repeat ($urandom % 6) @(negedge clk);
      if ($urandom % 40 == 0) do_refresh();
      issue(($urandom % 10) < 6, mk(r, $urandom % 1024), 4'($urandom));
    end
    drain();
    chk(readq.size() == 0, "R3 all reads answered", readq.size(), 0);
    chk(accq.size() == 0, "R1 all accesses reached the pins", accq.size(), 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule